// File: doc/BRIEF.md
# Double-Sampled Pipeline Stage Register with Error Recovery

This block is one register stage of a pipeline that runs with little or no timing margin. Every stage value is captured twice. The main register samples the input on the rising edge of the normal clock. A shadow register samples the same input on the rising edge of a second clock, `clk_late`. That clock has the same frequency and a fixed phase lag, so the input has more time to settle before the shadow capture. When the two captures disagree, the input was still moving when the main register sampled it. The block then raises an error flag and replaces the stage output with the shadow value on the next edge. For that one cycle it also asks the upstream stage to hold its data and marks the downstream slot as a bubble, so a wrong value never commits.

A window counter collects the detected errors over a fixed number of clock cycles. At the end of each window it compares the total with two thresholds. It issues a single-cycle request to raise the supply voltage when errors were frequent, and a request to lower it when they were rare. An external regulator can therefore run the supply close to the point of failure and does not need a fixed worst-case margin.

Top module: `spec_stage_reg`

## Requirements
- R1: With no late input change, `q_out` shows the value present at `d_in` at a `clk` rising edge from that edge onward, and `err_flag` stays 0.
- R2: If any bit of the main capture differs from the shadow capture taken at the following `clk_late` edge, `err_flag` is 1 for the cycle after the next `clk` edge. A difference confined to the least significant bit or to the most significant bit is detected.
- R3: An input change between a `clk` edge and the following `clk_late` edge that leaves the value unchanged raises no error.
- R4: On the edge that raises `err_flag`, `q_out` is loaded with the shadow capture instead of `d_in`. While upstream holds its data, `q_out` keeps that value on the next edge and `err_flag` returns to 0.
- R5: `stall_req` and `bubble_out` are 1 in exactly the cycles in which `err_flag` is 1.
- R6: Errors are counted over windows of `WINDOW` (default 1024) `clk` cycles, starting at the first edge after reset. After the last edge of a window, `volt_up` pulses for one cycle if the count in that window (including an error raised on that edge) is greater than `HI_THR` (default 8).
- R7: At the end of a window, `volt_down` pulses for one cycle if the count is less than `LO_THR` (default 2). A count from `LO_THR` to `HI_THR` inclusive gives no request.
- R8: At most one of `volt_up`/`volt_down` is 1 at a time, each pulse lasts one cycle, and pulses appear only in the cycle after a window's last edge.
- R9: Synchronous reset `rst` clears `q_out`, the shadow capture, `err_flag`, `stall_req`, `bubble_out`, both voltage requests, the error count and the window position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main stage clock |
| clk_late | input | 1 | Same-frequency clock with a fixed phase lag; clocks the shadow capture |
| rst | input | 1 | Synchronous reset, active high |
| d_in | input | WIDTH | Stage input from the upstream logic |
| q_out | output | WIDTH | Stage output, corrected after a detected timing error |
| err_flag | output | 1 | Timing error detected on the previous capture |
| stall_req | output | 1 | Asks the upstream stage to hold its data for one cycle |
| bubble_out | output | 1 | Marks the downstream slot as invalid for one cycle |
| volt_up | output | 1 | One-cycle request to raise the supply voltage |
| volt_down | output | 1 | One-cycle request to lower the supply voltage |

## Verification
The hardest situation to reach from the ports is a real disagreement between the two captures. It requires an input edge placed between a rising edge of `clk` and the next rising edge of `clk_late`. The bench changes `d_in` one time unit after a `clk` edge, which is inside the three-unit phase gap. It then holds the new value for the stall cycle, and so drives exactly the recovery path. A second hard area is the window logic at its thresholds: phases of the run place exactly `HI_THR`, exactly `LO_THR`, more than `HI_THR` and zero errors in separate windows. A reset in the middle of a busy window shows that the count restarts.

// File: rtl/spec_stage_pkg.sv
`timescale 1ns/1ps
package spec_stage_pkg;
    // Voltage request produced at the end of each error window
    typedef enum logic [1:0] {
        VREQ_NONE = 2'd0,
        VREQ_UP   = 2'd1,
        VREQ_DOWN = 2'd2
    } vreq_e;
endpackage

// File: rtl/shadow_capture.sv
`timescale 1ns/1ps
module shadow_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk_late,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] shadow_q
);
    logic [WIDTH-1:0] shadow_d;

    always_comb begin
        shadow_d = rst ? '0 : d_in;
    end

    always_ff @(posedge clk_late) begin
        shadow_q <= shadow_d;
    end
endmodule

// File: rtl/mismatch_detect.sv
`timescale 1ns/1ps
module mismatch_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] main_val,
    input  logic [WIDTH-1:0] late_val,
    output logic             mismatch
);
    logic [WIDTH-1:0] bit_diff;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_diff[i] = main_val[i] ^ late_val[i];
    end

    assign mismatch = |bit_diff;
endmodule

// File: rtl/rate_window.sv
`timescale 1ns/1ps
module rate_window
    import spec_stage_pkg::*;
#(
    parameter int WINDOW = 1024,
    parameter int HI_THR = 8,
    parameter int LO_THR = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  err_event,
    output vreq_e vreq
);
    localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HI_LIM   = CNT_W'(HI_THR);
    localparam logic [CNT_W-1:0] LO_LIM   = CNT_W'(LO_THR);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] cnt;
        vreq_e            vreq;
    } win_state_t;

    win_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        st_d      = st_q;
        st_d.vreq = VREQ_NONE;
        cnt_nx    = st_q.cnt;
        if (err_event && (st_q.cnt != CNT_MAX)) begin
            cnt_nx = st_q.cnt + 1'b1;
        end
        if (st_q.win == WIN_LAST) begin
            st_d.win = '0;
            st_d.cnt = '0;
            if (cnt_nx > HI_LIM) begin
                st_d.vreq = VREQ_UP;
            end else if (cnt_nx < LO_LIM) begin
                st_d.vreq = VREQ_DOWN;
            end
        end else begin
            st_d.win = st_q.win + 1'b1;
            st_d.cnt = cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{win: '0, cnt: '0, vreq: VREQ_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign vreq = st_q.vreq;
endmodule

// File: rtl/spec_stage_reg.sv
`timescale 1ns/1ps
module spec_stage_reg
    import spec_stage_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int WINDOW = 1024,
    parameter int HI_THR = 8,
    parameter int LO_THR = 2
) (
    input  logic             clk,
    input  logic             clk_late,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out,
    output logic             err_flag,
    output logic             stall_req,
    output logic             bubble_out,
    output logic             volt_up,
    output logic             volt_down
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             err;
    } stage_t;

    stage_t           st_d, st_q;
    logic [WIDTH-1:0] shadow_q;
    logic             mismatch;
    vreq_e            vreq;

    shadow_capture #(.WIDTH(WIDTH)) i_shadow (
        .clk_late (clk_late),
        .rst      (rst),
        .d_in     (d_in),
        .shadow_q (shadow_q)
    );

    mismatch_detect #(.WIDTH(WIDTH)) i_cmp (
        .main_val (st_q.data),
        .late_val (shadow_q),
        .mismatch (mismatch)
    );

    rate_window #(
        .WINDOW (WINDOW),
        .HI_THR (HI_THR),
        .LO_THR (LO_THR)
    ) i_rate (
        .clk       (clk),
        .rst       (rst),
        .err_event (mismatch),
        .vreq      (vreq)
    );

    // On a mismatch the late capture replaces the stage value
    always_comb begin
        st_d.err  = mismatch;
        st_d.data = mismatch ? shadow_q : d_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{data: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_out      = st_q.data;
    assign err_flag   = st_q.err;
    assign stall_req  = st_q.err;
    assign bubble_out = st_q.err;
    assign volt_up    = (vreq == VREQ_UP);
    assign volt_down  = (vreq == VREQ_DOWN);
endmodule

// File: rtl/spec_stage_chk.sv
`timescale 1ns/1ps
module spec_stage_chk #(
    parameter int WIDTH  = 8,
    parameter int WINDOW = 1024
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] q_out,
    input logic [WIDTH-1:0] shadow,
    input logic             err_flag,
    input logic             stall_req,
    input logic             bubble_out,
    input logic             volt_up,
    input logic             volt_down
);
    localparam int PW = $clog2(WINDOW) + 1;
    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || (pos_q == PW'(WINDOW - 1))) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q_out == '0) && !err_flag && !stall_req && !bubble_out && !volt_up && !volt_down);

    // R8
    one_request_chk: assert property (@(posedge clk) disable iff (rst)
        !(volt_up && volt_down));

    // R8
    window_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (volt_up || volt_down) |-> (pos_q == '0));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (volt_up || volt_down) |=> !(volt_up || volt_down));

    // R4
    recover_value_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (q_out == $past(shadow)));

    // R2
    real_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> ($past(q_out) != $past(shadow)));
endmodule

bind spec_stage_reg spec_stage_chk #(
    .WIDTH  (WIDTH),
    .WINDOW (WINDOW)
) i_spec_stage_chk (
    .clk        (clk),
    .rst        (rst),
    .q_out      (q_out),
    .shadow     (shadow_q),
    .err_flag   (err_flag),
    .stall_req  (stall_req),
    .bubble_out (bubble_out),
    .volt_up    (volt_up),
    .volt_down  (volt_down)
);

// File: tb/test_spec_stage_reg.sv
`timescale 1ns/1ps
module test_spec_stage_reg;
    localparam int W   = 1024;
    localparam int HI  = 8;
    localparam int LO  = 2;
    localparam int NV  = 10;
    // {late change, value before edge, value after edge}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00}, {1'b0, 8'hA5, 8'hA5}, {1'b1, 8'h3C, 8'h3D},
        {1'b1, 8'h12, 8'h92}, {1'b1, 8'h55, 8'hAA}, {1'b1, 8'h77, 8'h77},
        {1'b0, 8'hFF, 8'hFF}, {1'b1, 8'hFF, 8'h00}, {1'b1, 8'h01, 8'h80},
        {1'b1, 8'hC3, 8'h3C}
    };

    logic       clk, clk_late, rst;
    logic [7:0] d_in, q_out;
    logic       err_flag, stall_req, bubble_out, volt_up, volt_down;
    int n_chk = 0, n_fail = 0, cyc = 0, win_errs = 0, windows = 0;

    spec_stage_reg #(.WIDTH(8), .WINDOW(W), .HI_THR(HI), .LO_THR(LO)) i_spec_stage_reg (
        .clk(clk), .clk_late(clk_late), .rst(rst), .d_in(d_in), .q_out(q_out),
        .err_flag(err_flag), .stall_req(stall_req), .bubble_out(bubble_out),
        .volt_up(volt_up), .volt_down(volt_down)
    );

    initial begin clk = 0; forever #4 clk = ~clk; end
    initial begin clk_late = 0; #3; forever #4 clk_late = ~clk_late; end

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Window monitor: counts flagged errors and checks requests at window ends (R6 R7 R8)
    always begin
        @(negedge clk); #2;
        if (rst) begin
            win_errs = 0;
        end else if (cyc != 0) begin
            if (err_flag) win_errs++;
            if (cyc % W == 0) begin
                chk("R6", "volt_up at window end", 32'(volt_up), 32'(win_errs > HI));
                chk("R7", "volt_down at window end", 32'(volt_down), 32'(win_errs < LO));
                windows++;
                win_errs = 0;
            end else if (volt_up || volt_down) begin
                chk("R8", "request inside window", {30'd0, volt_up, volt_down}, 32'd0);
            end
        end
    end

    task automatic apply(logic late, logic [7:0] a, logic [7:0] b);
        logic exp_err;
        exp_err = late && (a != b);
        @(negedge clk) d_in = a;
        @(posedge clk);
        if (late) begin #1 d_in = b; end
        @(negedge clk);
        chk("R1", "q_out after capture", 32'(q_out), 32'(a));
        chk("R1", "no early error", 32'(err_flag), 32'd0);
        @(negedge clk);
        chk(exp_err ? "R2" : "R3", "err_flag", 32'(err_flag), 32'(exp_err));
        chk("R5", "stall_req", 32'(stall_req), 32'(exp_err));
        chk("R5", "bubble_out", 32'(bubble_out), 32'(exp_err));
        chk("R4", "q_out after compare", 32'(q_out), 32'(late ? b : a));
        if (exp_err) begin
            @(negedge clk);
            chk("R4", "recovered q_out held", 32'(q_out), 32'(b));
            chk("R4", "err_flag cleared", 32'(err_flag), 32'd0);
            chk("R5", "stall_req cleared", 32'(stall_req), 32'd0);
        end
    endtask

    task automatic burst(int n, int seed);
        for (int i = 0; i < n; i++) begin
            apply(1'b1, 8'(seed + i * 29), ~8'(seed + i * 29));
        end
    endtask

    task automatic wait_cyc(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic check_reset_state();
        chk("R9", "q_out in reset", 32'(q_out), 32'd0);
        chk("R9", "err_flag in reset", 32'(err_flag), 32'd0);
        chk("R9", "stall/bubble in reset", {30'd0, stall_req, bubble_out}, 32'd0);
        chk("R9", "voltage requests in reset", {30'd0, volt_up, volt_down}, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; d_in = 8'h00;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 0;
        // Window 1: table vectors (6 real errors) plus a burst: above HI
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
        end
        burst(6, 8'h21);
        // Window 2 stays quiet: below LO
        wait_cyc(2 * W + 5);
        // Window 3: exactly HI errors, no request
        burst(HI, 8'h47);
        wait_cyc(3 * W + 5);
        // Window 4: exactly LO errors, no request
        burst(LO, 8'h05);
        // Window 5 quiet
        wait_cyc(5 * W + 5);
        // Window 6: many errors, then reset restarts counting
        burst(HI + 1, 8'h63);
        @(negedge clk) rst = 1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 0;
        @(negedge clk);
        chk("R9", "no error after reset", 32'(err_flag), 32'd0);
        while (windows < 6) @(negedge clk);
        chk("R8", "window ends seen", 32'(windows), 32'd6);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule